// File: doc/BRIEF.md
# Shadow Micro-TLB

This block is a small, fully associative translation cache that sits between an access path (instruction fetch or data load/store) and the shared main TLB. A requester presents a tag made of the address-space bit, the process identifier and the virtual page number. When a valid entry holds that tag, the stored translation comes back in the same cycle and the main TLB is not touched.

On a miss the block stalls its lookup port, raises a request to the main TLB and waits for the answer. It then installs the returned entry in the slot chosen by a round-robin pointer and hands the translation to the requester. If the main TLB has no entry either, the requester sees a fault and nothing is installed. A single invalidate-all input empties the whole cache in one cycle and abandons any refill in flight. The owner raises it, for example, whenever the main TLB is rewritten. No software ever picks or clears entries.

The depth is a parameter. The fetch path uses four entries and the load/store path uses eight.

Top module: `utlb`

## Requirements
- R1: After reset every entry is invalid, `lkReady` is 1, and `refReqValid` and `respValid` are 0, so the first lookup of any tag misses.
- R2: When `lkValid`, `lkReady` and a valid entry's tag equal to `lkTag` all hold in the same cycle, `respValid`=1, `respFault`=0 and `respData` is that entry's stored data in that cycle, and no refill request follows.
- R3: At most one valid entry ever matches a given tag.
- R4: A lookup accepted without a match raises `refReqValid` from the next cycle, with `refReqTag` equal to the missed tag. It stays high until `refRspValid` or `flushAll`. The main TLB is requested only after such a miss.
- R5: From the cycle after a miss up to and including the cycle that delivers its result, `lkReady` is 0. It is 1 again in the following cycle.
- R6: If the main TLB answers L cycles after the request first shows, with L at least 1, the result appears on `respValid` exactly 2+L cycles after the lookup cycle. That makes 3 cycles when L=1. A successful answer (`refRspMiss`=0) gives `respFault`=0, returns `refRspData` on `respData`, and installs the entry.
- R7: An answer with `refRspMiss`=1 gives `respValid`=1 and `respFault`=1. Nothing is installed, the replacement pointer does not move, and a later lookup of that tag misses again.
- R8: Installs fill slots 0, 1, …, ENTRIES-1 and then wrap, so each install evicts the entry installed ENTRIES installs earlier. The pointer restarts at slot 0 after reset and after `flushAll`.
- R9: In a cycle with `flushAll`=1, `lkReady` is 0. From the next cycle every entry is invalid, any pending refill is dropped with no `respValid` for it, and `refReqValid` is 0.
- R10: A `refRspValid` pulse while no refill is pending has no effect. It gives no `respValid` and installs nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| flushAll | input | 1 | Invalidate every entry and cancel any refill |
| lkValid | input | 1 | Lookup request present |
| lkTag | input | TAG_W | Lookup tag: {AS, PID, VPN} |
| lkReady | output | 1 | Lookup can be accepted this cycle |
| respValid | output | 1 | Result valid this cycle |
| respFault | output | 1 | Result is a main-TLB miss |
| respData | output | DATA_W | Translation (real page number and attributes) |
| refReqValid | output | 1 | Refill request to the main TLB |
| refReqTag | output | TAG_W | Tag being refilled |
| refRspValid | input | 1 | Main TLB answer present |
| refRspMiss | input | 1 | Main TLB holds no entry for the tag |
| refRspData | input | DATA_W | Entry returned by the main TLB |

## Verification
The bench builds the block with ENTRIES=4, TAG_W=6 and DATA_W=16. The narrow tag lets a random pool of ten tags give frequent hits, evictions and repeated main-TLB misses. With four slots, round-robin wrap-around and eviction of the oldest install come up within a few refills. The main-TLB model answers after a random 1 to 3 cycles, so the 2+L timing is checked at more than its minimum. Invalidate-all is injected both while idle and in the middle of a refill.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  // Strobes from the control FSM to the entry datapath
  typedef struct packed {
    logic captureTag;  // remember the missed tag
    logic latchFill;   // capture the main-TLB answer for delivery
    logic install;     // write the answer into the slot under the pointer
    logic flush;       // clear all valid bits, restart the pointer
  } utlbStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DONE = 2'd2
  } utlbState_t;

endpackage

// File: rtl/utlb_data.sv
module utlb_data
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 29,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  utlbStrobe_t       strobe,
  input  logic [TAG_W-1:0]  lkTag,
  input  logic              refRspMiss,
  input  logic [DATA_W-1:0] refRspData,
  output logic              hit,
  output logic [DATA_W-1:0] hitData,
  output logic [TAG_W-1:0]  pendTag,
  output logic [DATA_W-1:0] doneData,
  output logic              doneFault
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] entryValid;
  logic [TAG_W-1:0]   entryTag  [ENTRIES];
  logic [DATA_W-1:0]  entryData [ENTRIES];
  logic [ENTRIES-1:0] hitVec;
  logic [PTR_W-1:0]   fillPtr;

  // One comparator and one write port per slot
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : gSlot
    assign hitVec[gi] = entryValid[gi] && (entryTag[gi] == lkTag);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryValid[gi] <= 1'b0;
        entryTag[gi]   <= '0;
        entryData[gi]  <= '0;
      end else if (strobe.flush) begin
        entryValid[gi] <= 1'b0;
      end else if (strobe.install && (fillPtr == PTR_W'(gi))) begin
        entryValid[gi] <= 1'b1;
        entryTag[gi]   <= pendTag;
        entryData[gi]  <= refRspData;
      end
    end
  end

  assign hit = |hitVec;

  always_comb begin
    hitData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitData = hitData | entryData[i];
    end
  end

  // Round-robin replacement pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillPtr <= '0;
    end else if (strobe.flush) begin
      fillPtr <= '0;
    end else if (strobe.install) begin
      fillPtr <= (fillPtr == LAST_SLOT) ? '0 : fillPtr + 1'b1;
    end
  end

  // Missed tag and the captured answer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendTag   <= '0;
      doneData  <= '0;
      doneFault <= 1'b0;
    end else begin
      if (strobe.captureTag) pendTag <= lkTag;
      if (strobe.latchFill) begin
        doneData  <= refRspData;
        doneFault <= refRspMiss;
      end
    end
  end

  // R3
  single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R8
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.install && !strobe.flush) |=>
      (fillPtr == (($past(fillPtr) == LAST_SLOT) ? '0 : $past(fillPtr) + 1'b1)));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (entryValid == '0) && (fillPtr == '0));

endmodule

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
  import utlb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flushAll,
  input  logic        lkValid,
  input  logic        hit,
  input  logic        refRspValid,
  input  logic        refRspMiss,
  output utlbStrobe_t strobe,
  output logic        lkReady,
  output logic        refReqValid,
  output logic        hitValid,
  output logic        doneValid
);

  utlbState_t state, stateNext;
  logic       accept;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    lkReady     = 1'b0;
    refReqValid = 1'b0;
    hitValid    = 1'b0;
    doneValid   = 1'b0;
    accept      = 1'b0;
    strobe.flush = flushAll;

    unique case (state)
      ST_IDLE: begin
        lkReady  = !flushAll;
        accept   = lkValid && !flushAll;
        hitValid = accept && hit;
        if (accept && !hit) begin
          strobe.captureTag = 1'b1;
          stateNext = ST_REQ;
        end
      end
      ST_REQ: begin
        refReqValid = 1'b1;
        if (flushAll) begin
          stateNext = ST_IDLE;
        end else if (refRspValid) begin
          strobe.latchFill = 1'b1;
          strobe.install   = !refRspMiss;
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R5
  stall_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReqValid || doneValid) |-> !lkReady);

  // R4
  req_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refReqValid) |-> $past(lkValid && lkReady && !hit));

  // R6
  answer_delivers_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReqValid && refRspValid && !flushAll) |=> doneValid);

  // R9
  flush_cancels_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (!refReqValid && !doneValid));

  // R10
  stray_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refRspValid && !refReqValid) |=> !doneValid);

endmodule

// File: rtl/utlb.sv
module utlb
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 29,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              lkValid,
  input  logic [TAG_W-1:0]  lkTag,
  output logic              lkReady,
  output logic              respValid,
  output logic              respFault,
  output logic [DATA_W-1:0] respData,
  output logic              refReqValid,
  output logic [TAG_W-1:0]  refReqTag,
  input  logic              refRspValid,
  input  logic              refRspMiss,
  input  logic [DATA_W-1:0] refRspData
);

  utlbStrobe_t       strobe;
  logic              hit, hitValid, doneValid, doneFault;
  logic [DATA_W-1:0] hitData, doneData;

  utlb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flushAll    (flushAll),
    .lkValid     (lkValid),
    .hit         (hit),
    .refRspValid (refRspValid),
    .refRspMiss  (refRspMiss),
    .strobe      (strobe),
    .lkReady     (lkReady),
    .refReqValid (refReqValid),
    .hitValid    (hitValid),
    .doneValid   (doneValid)
  );

  utlb_data #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lkTag      (lkTag),
    .refRspMiss (refRspMiss),
    .refRspData (refRspData),
    .hit        (hit),
    .hitData    (hitData),
    .pendTag    (refReqTag),
    .doneData   (doneData),
    .doneFault  (doneFault)
  );

  assign respValid = hitValid || doneValid;
  assign respFault = doneValid && doneFault;
  assign respData  = doneValid ? doneData : hitData;

  // R2
  hit_no_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (!respFault && !refReqValid));

endmodule

// File: tb/sim_utlb.sv
module sim_utlb;

  localparam int ENT = 4;
  localparam int TW  = 6;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          flushAll = 1'b0;
  logic          lkValid = 1'b0;
  logic [TW-1:0] lkTag = '0;
  logic          lkReady, respValid, respFault, refReqValid;
  logic [DW-1:0] respData;
  logic [TW-1:0] refReqTag;
  logic          refRspValid = 1'b0;
  logic          refRspMiss = 1'b0;
  logic [DW-1:0] refRspData = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  logic [TW-1:0] mTag [ENT];
  bit            mVal [ENT];
  int            mPtr;

  always #2 clk = ~clk;  // 250 MHz

  utlb #(.ENTRIES(ENT), .TAG_W(TW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .flushAll(flushAll),
    .lkValid(lkValid), .lkTag(lkTag), .lkReady(lkReady),
    .respValid(respValid), .respFault(respFault), .respData(respData),
    .refReqValid(refReqValid), .refReqTag(refReqTag),
    .refRspValid(refRspValid), .refRspMiss(refRspMiss), .refRspData(refRspData)
  );

  function automatic logic [DW-1:0] mainData(logic [TW-1:0] t);
    return {t, ~t, 4'h5};
  endfunction

  function automatic bit mainMiss(logic [TW-1:0] t);
    return (t % 5) == 3;
  endfunction

  function automatic int modelFind(logic [TW-1:0] t);
    for (int i = 0; i < ENT; i++) if (mVal[i] && mTag[i] == t) return i;
    return -1;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < ENT; i++) mVal[i] = 0;
    mPtr = 0;
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One lookup; lat = answer delay; flushMid = flush instead of answering
  task automatic doLookup(logic [TW-1:0] t, int lat, bit flushMid);
    int idx;
    idx = modelFind(t);
    @(negedge clk);
    lkValid = 1'b1; lkTag = t;
    #1;
    chk(lkReady == 1'b1, "R5 ready idle", 32'(lkReady), 1);
    if (idx >= 0) begin
      chk(respValid && !respFault && respData == mainData(t), "R2 hit",
          {respValid, respFault, 14'd0, respData}, {2'b10, 14'd0, mainData(t)});
      @(negedge clk);
      lkValid = 1'b0;
      #1;
      chk(refReqValid == 1'b0, "R4 no request on hit", 32'(refReqValid), 0);
      return;
    end
    chk(respValid == 1'b0, "R4 miss no resp", 32'(respValid), 0);
    @(negedge clk);
    lkValid = 1'b0;
    #1;
    chk(refReqValid && refReqTag == t, "R4 request tag",
        {refReqValid, 15'd0, 10'd0, refReqTag}, {1'b1, 15'd0, 10'd0, t});
    chk(!lkReady && !respValid, "R5 stall", {lkReady, respValid}, 0);
    for (int k = 1; k < lat; k++) begin
      @(negedge clk);
      #1;
      chk(refReqValid && !lkReady && !respValid, "R4 request held",
          {refReqValid, lkReady, respValid}, 3'b100);
    end
    @(negedge clk);
    if (flushMid) begin
      flushAll = 1'b1;
      #1;
      chk(lkReady == 1'b0, "R9 ready low in flush", 32'(lkReady), 0);
      @(negedge clk);
      flushAll = 1'b0;
      #1;
      chk(!respValid && !refReqValid && lkReady, "R9 refill cancelled",
          {respValid, refReqValid, lkReady}, 3'b001);
      modelClear();
      return;
    end
    refRspValid = 1'b1; refRspMiss = mainMiss(t); refRspData = mainData(t);
    @(negedge clk);
    refRspValid = 1'b0; refRspMiss = 1'b0; refRspData = '0;
    #1;
    if (mainMiss(t)) begin
      chk(respValid && respFault && !lkReady, "R7 fault delivered",
          {respValid, respFault, lkReady}, 3'b110);
    end else begin
      chk(respValid && !respFault && respData == mainData(t) && !lkReady,
          "R6 translation at 2+L",
          {respValid, respFault, lkReady, 13'd0, respData},
          {3'b100, 13'd0, mainData(t)});
      mTag[mPtr] = t; mVal[mPtr] = 1; mPtr = (mPtr + 1) % ENT;
    end
    @(negedge clk);
    #1;
    chk(lkReady && !respValid && !refReqValid, "R5 ready returns",
        {lkReady, respValid, refReqValid}, 3'b100);
  endtask

  task automatic doFlush();
    @(negedge clk);
    flushAll = 1'b1;
    #1;
    chk(lkReady == 1'b0, "R9 ready low in flush", 32'(lkReady), 0);
    @(negedge clk);
    flushAll = 1'b0;
    modelClear();
  endtask

  task automatic strayAnswer(logic [TW-1:0] t);
    @(negedge clk);
    refRspValid = 1'b1; refRspMiss = 1'b0; refRspData = mainData(t);
    #1;
    chk(!respValid && !refReqValid, "R10 stray answer", {respValid, refReqValid}, 0);
    @(negedge clk);
    refRspValid = 1'b0; refRspData = '0;
    #1;
    chk(!respValid, "R10 stray no delivery", 32'(respValid), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(lkReady && !refReqValid && !respValid, "R1 reset state",
        {lkReady, refReqValid, respValid}, 3'b100);

    // R1: first lookup misses; R6 with L=1 gives 3 cycles
    doLookup(6'd1, 1, 0);
    doLookup(6'd1, 1, 0);  // R2 hit
    doLookup(6'd2, 2, 0);
    doLookup(6'd4, 1, 0);
    doLookup(6'd5, 3, 0);
    // R8: fifth install evicts slot 0 (tag 1)
    doLookup(6'd6, 1, 0);
    doLookup(6'd1, 1, 0);  // R8 tag 1 misses again, evicts tag 2
    doLookup(6'd4, 1, 0);  // R8 tag 4 still present
    doLookup(6'd2, 1, 0);  // R8 tag 2 was evicted
    // R7: main-TLB miss, nothing installed, repeats as a miss
    doLookup(6'd3, 1, 0);
    doLookup(6'd3, 2, 0);
    doLookup(6'd5, 1, 0);  // R7 pointer did not move: tag 5 evicted? model decides
    // R10: stray answer ignored, then tag 9 still misses
    strayAnswer(6'd9);
    doLookup(6'd9, 1, 0);
    // R9: flush idle, then everything misses; flush mid-refill
    doFlush();
    doLookup(6'd4, 1, 0);
    doLookup(6'd4, 1, 0);
    doLookup(6'd7, 2, 1);
    doLookup(6'd4, 1, 0);  // R9 cleared by mid-refill flush

    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 20;
      if (r == 0) doFlush();
      else if (r == 1) strayAnswer(6'($urandom % 10));
      else doLookup(6'($urandom % 10), 1 + ($urandom % 3), ($urandom % 25) == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule